// File: doc/BRIEF.md
# APB UART Register Front End

This block is the bus-facing register layer of a simple serial port. An APB slave with no wait states decodes a small register window: a data register, a read-only status register, a control register and a scaler register that holds nothing. Bytes coming in from a serial receiver enter a circular receive queue. Each read of the data register hands out the oldest queued byte and removes it from the queue.

A write to the data register passes its low byte to a transmit output that uses a valid/ready handshake. Separate control bits let received and transmitted traffic through and arm a one-cycle interrupt pulse for each direction. The data register also answers at byte offset 3, so software that reads or writes only one byte lane reaches it there. The bit-level shifter, baud timing, parity and flow control sit outside this block.

Top module: `apb_uart_regs`

## Requirements
- R1: After reset the control register reads 0, status reads 0x006 (bits 1 and 2 set), irq is low and tx_valid is low.
- R2: A byte on rx_valid/rx_data enters the receive queue only while control bit 0 is set, and it then sets status bit 0 (data ready). While bit 0 is clear the byte is dropped.
- R3: A read at offset 0x00 or 0x03 returns the oldest queued byte in bits 7:0, with the upper bits 0, and removes that byte. Status bit 0 clears when the queue empties. A read of an empty queue returns 0.
- R4: An accepted received byte raises irq for exactly one cycle, one cycle later, when control bit 2 is set. With bit 2 clear, irq stays low.
- R5: A write at offset 0x00 or 0x03 while control bit 1 is set and no byte is pending drives pwdata[7:0] on tx_data with tx_valid high. The byte is held until tx_ready. The write is ignored when bit 1 is clear or a byte is still pending.
- R6: An accepted transmit write raises irq for one cycle, one cycle later, when control bit 3 is set.
- R7: Status bits 1 and 2 are set while no transmit byte is pending, and bit 9 is set while one is. Bit 8 is set while the queue holds at least DEPTH/2 bytes, and bit 10 while it is full.
- R8: A byte that arrives while the queue is full and receive is enabled is dropped, and it sets status bit 4 (overrun). Writing status with bit 4 set clears overrun. Writes to status change no other bit.
- R9: Control at 0x08 reads back all 32 written bits. The scaler at 0x0C reads 0 and ignores writes. Any other offset reads 0.
- R10: pready is always high. Only an access-phase read (psel, penable high, pwrite low) of the data register removes a byte, so a setup-phase read does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit consumer takes the byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The receive queue is driven with short bursts read back through both data offsets, which exposes ordering errors and alias decode faults. It is also filled to the full mark and pushed once more, which separates the half and full flags and shows whether the overflow byte is discarded or overwrites a stored entry. On the transmit side, a queue of expected bytes is compared at each handshake. That queue catches writes that should have been dropped because the enable was off or a byte was already pending, and it catches bytes that were lost. Irq is sampled with each enable on and off, which tells a missing pulse from a stuck or misrouted one.

// File: rtl/apb_uart_regs.sv
module apb_uart_regs #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH / 2);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic [31:0]   ctrl_q;
  logic          ovr_q;

  wire acc     = psel & penable;
  wire is_data = (paddr == 8'h00) | (paddr == 8'h03);
  wire is_stat = paddr == 8'h04;
  wire is_ctrl = paddr == 8'h08;
  wire empty   = count == '0;
  wire full    = count == CNT_FULL;
  wire half    = count >= CNT_HALF;
  wire rx_in   = rx_valid & ctrl_q[0];
  wire push    = rx_in & ~full;
  wire pop     = acc & ~pwrite & is_data & ~empty;
  wire tx_take = acc & pwrite & is_data & ctrl_q[1] & ~tx_valid;

  wire [31:0] status = {21'b0, full, tx_valid, half, 1'b0, 2'b0, ovr_q,
                        1'b0, ~tx_valid, ~tx_valid, ~empty};

  assign pready = 1'b1;

  always_comb begin
    prdata = '0;
    if (is_data)      prdata = empty ? 32'h0 : {24'h0, mem[rptr]};
    else if (is_stat) prdata = status;
    else if (is_ctrl) prdata = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      ctrl_q   <= '0;
      ovr_q    <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      irq      <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count <= count + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      if (acc & pwrite & is_ctrl) ctrl_q <= pwdata;
      if (rx_in & full)                          ovr_q <= 1'b1;
      else if (acc & pwrite & is_stat & pwdata[4]) ovr_q <= 1'b0;
      if (tx_take) begin
        tx_valid <= 1'b1;
        tx_data  <= pwdata[7:0];
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
      irq <= (push & ctrl_q[2]) | (tx_take & ctrl_q[3]);
    end
  end
endmodule

// File: rtl/apb_uart_regs_chk.sv
module apb_uart_regs_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       psel,
  input logic                       penable,
  input logic                       pwrite,
  input logic                       pready,
  input logic                       rx_valid,
  input logic                       tx_valid,
  input logic [7:0]                 tx_data,
  input logic                       tx_ready,
  input logic                       irq,
  input logic [31:0]                ctrl_q,
  input logic [$clog2(DEPTH):0]     count
);
  localparam int CW = $clog2(DEPTH) + 1;

  a_r10_pready_high: assert property (@(posedge clk) disable iff (!rst_n) pready);

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_valid || (psel && penable && pwrite)));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r2_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] && !(psel && penable && !pwrite) |=> count == $past(count));
endmodule

bind apb_uart_regs apb_uart_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .pready(pready), .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_ready(tx_ready), .irq(irq), .ctrl_q(ctrl_q), .count(count)
);

// File: tb/tb_apb_uart_regs.sv
module tb_apb_uart_regs;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready, rx_valid = 0, tx_valid, tx_ready = 0, irq;
  logic [7:0] rx_data = 0, tx_data;
  int total = 0, bad = 0;
  logic [7:0] exp_tx[$];
  logic [31:0] rd;

  always #5 clk = ~clk;

  apb_uart_regs dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(logic [7:0] a, logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(logic [7:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge clk); #1 penable = 1;
    #3 d = prdata;
    if (!pready) check("R10 pready", {31'b0, pready}, 1);
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic rx_push(logic [7:0] b);
    rx_valid = 1; rx_data = b;
    @(posedge clk); #1 rx_valid = 0;
  endtask

  task automatic tx_drain();
    tx_ready = 1;
    @(posedge clk); #1 tx_ready = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) check("R5 unexpected tx", {24'b0, tx_data}, 32'hFFFF_FFFF);
      else check("R5 tx byte", {24'b0, tx_data}, {24'b0, exp_tx.pop_front()});
    end
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    apb_rd(8'h04, rd); check("R1 status", rd, 32'h006);
    apb_rd(8'h08, rd); check("R1 ctrl", rd, 0);
    check("R1 irq/tx_valid", {irq, tx_valid}, 0);

    rx_push(8'h11);
    apb_rd(8'h04, rd); check("R2 disabled rx dropped", rd, 32'h006);
    apb_rd(8'h00, rd); check("R3 empty read", rd, 0);

    apb_wr(8'h08, 32'h5);
    rx_push(8'hA5);
    check("R4 irq pulse", irq, 1);
    @(posedge clk); #1 check("R4 irq one cycle", irq, 0);
    apb_rd(8'h04, rd); check("R2 data ready", rd, 32'h007);
    rx_push(8'h3C); rx_push(8'h7E);
    apb_rd(8'h00, rd); check("R3 oldest", rd, 32'hA5);
    apb_rd(8'h03, rd); check("R3 alias offset 3", rd, 32'h3C);
    apb_rd(8'h00, rd); check("R3 third", rd, 32'h7E);
    apb_rd(8'h04, rd); check("R3 data ready clears", rd, 32'h006);

    apb_wr(8'h08, 32'h1);
    rx_push(8'h42);
    check("R4 no irq when disabled", irq, 0);
    psel = 1; pwrite = 0; paddr = 8'h00; penable = 0;
    @(posedge clk); #1 psel = 0;
    apb_rd(8'h04, rd); check("R10 setup phase no pop", rd, 32'h007);
    apb_rd(8'h00, rd); check("R10 byte still there", rd, 32'h42);

    for (int i = 0; i < 8; i++) rx_push(8'(i * 3 + 1));
    apb_rd(8'h04, rd); check("R7 half", rd, 32'h107);
    for (int i = 8; i < 16; i++) rx_push(8'(i * 3 + 1));
    apb_rd(8'h04, rd); check("R7 full", rd, 32'h507);
    rx_push(8'hEE);
    apb_rd(8'h04, rd); check("R8 overrun set", rd, 32'h517);
    apb_wr(8'h04, 32'hFFFF_FFFF);
    apb_rd(8'h04, rd); check("R8 overrun cleared only", rd, 32'h507);
    for (int i = 0; i < 16; i++) begin
      apb_rd(8'h00, rd); check("R8 order kept after overflow", rd, 32'(i * 3 + 1));
    end
    apb_rd(8'h00, rd); check("R8 dropped byte absent", rd, 0);

    apb_wr(8'h08, 32'h0A);
    exp_tx.push_back(8'hC3);
    apb_wr(8'h00, 32'h1234_56C3);
    check("R6 tx irq", irq, 1);
    check("R5 tx_valid", tx_valid, 1);
    apb_rd(8'h04, rd); check("R7 tx pending", rd, 32'h200);
    apb_wr(8'h03, 32'h55);
    check("R6 no irq on dropped write", irq, 0);
    tx_drain();
    apb_rd(8'h04, rd); check("R7 tx idle", rd, 32'h006);
    exp_tx.push_back(8'h99);
    apb_wr(8'h03, 32'h99);
    tx_drain();
    apb_wr(8'h08, 32'h08);
    apb_wr(8'h00, 32'h44);
    check("R5 disabled tx", {irq, tx_valid}, 0);
    check("R5 all tx seen", exp_tx.size(), 0);

    apb_wr(8'h08, 32'hDEAD_BEEE);
    apb_rd(8'h08, rd); check("R9 ctrl readback", rd, 32'hDEAD_BEEE);
    apb_wr(8'h0C, 32'hFFFF_FFFF);
    apb_rd(8'h0C, rd); check("R9 scaler zero", rd, 0);
    apb_rd(8'h10, rd); check("R9 other offset", rd, 0);
    apb_rd(8'h40, rd); check("R9 unmapped", rd, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule